// File: doc/BRIEF.md
# Incremental Bus Precoder and Decoder

This block packs an N-bit data word onto N+1 bus lines so that every data bit is carried by the relation between two neighbouring lines rather than by one line against a fixed reference. The transmit side holds line 0 at a configurable constant and sets each later line to the line below it XORed with the matching data bit. Line values are therefore the running (prefix) XOR of the word, seeded by the constant. The receive side takes the N+1 sliced line bits and recovers each data bit as the XOR of its two adjacent lines. That result does not depend on the constant on line 0, nor on an inversion of the whole bus.

The running XOR across the word is the long logic path. A parameter picks a linear ripple chain or a log-depth parallel-prefix tree for it. A separate latency parameter places a fixed number of register stages behind the scan so that retiming can spread the XOR levels. A valid bit travels with every word through both sides. Each output register loads only when a valid word reaches it, so outputs hold between words.

Top module: `incr_bus_codec`

## Requirements
- R1: While rst_ni is low, line_valid_o and rx_valid_o are 0 and line_o and rx_data_o are all zeros.
- R2: Whenever line_valid_o is 1, line_o[0] equals the SEED parameter.
- R3: For a word accepted on tx_data_i, the emitted lines satisfy line_o[k+1] = line_o[k] XOR tx_data_i[k] for k = 0..WIDTH-1. As a consequence, line_o[WIDTH] equals SEED XOR the parity of the word.
- R4: A word presented with tx_valid_i = 1 before rising edge t appears on line_o with line_valid_o = 1 after rising edge t+ENC_LAT-1. One word per cycle is accepted with no gap.
- R5: A line vector presented with rx_valid_i = 1 yields rx_data_o[k] = rx_line_i[k+1] XOR rx_line_i[k] one cycle later, with rx_valid_o = 1. When rx_valid_i = 0, rx_valid_o is 0 one cycle later.
- R6: The decoded word is the same when every bit of rx_line_i is inverted, so decoding does not depend on the level of line 0.
- R7: Words presented with the valid input at 0 are ignored. line_o holds its last value while line_valid_o is 0, and rx_data_o holds its last value while rx_valid_o is 0.
- R8: The ripple (CHAIN = CHAIN_RIPPLE) and prefix-tree (CHAIN = CHAIN_PREFIX) variants produce identical line values for the same word and seed. Fed back through the decoder, both return the original word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | WIDTH | Data word to encode |
| tx_valid_i | input | 1 | Qualifies tx_data_i |
| line_o | output | WIDTH+1 | Encoded line values, line 0 is the seed line |
| line_valid_o | output | 1 | Qualifies line_o |
| rx_line_i | input | WIDTH+1 | Sliced line values from the bus |
| rx_valid_i | input | 1 | Qualifies rx_line_i |
| rx_data_o | output | WIDTH | Decoded data word |
| rx_valid_o | output | 1 | Qualifies rx_data_o |

## Verification
The bench builds two copies at WIDTH = 6. The first uses the prefix tree, seed 0 and a two-stage encode latency. The second uses the ripple chain, seed 1 and a three-stage latency. With both copies, a changed seed, a changed scan variant and a changed pipeline depth must each reproduce the same round trip, and each is checked against its own cycle-exact schedule. Each copy's lines are looped back into its decoder, and the whole bus is randomly inverted on the way. Seed independence and inversion independence are therefore exercised on every word. Idle gaps with garbage data probe the hold behaviour.

// File: rtl/incr_bus_pkg.sv
package incr_bus_pkg;
  typedef enum logic {
    CHAIN_RIPPLE = 1'b0,
    CHAIN_PREFIX = 1'b1
  } chain_e;
endpackage

// File: rtl/incr_xor_scan.sv
module incr_xor_scan
  import incr_bus_pkg::*;
#(
  parameter int     WIDTH = 6,
  parameter chain_e CHAIN = CHAIN_PREFIX
) (
  input  logic             seed_i,
  input  logic [WIDTH-1:0] bits_i,
  output logic [WIDTH:0]   lines_o
);
  localparam int LW   = WIDTH + 1;
  localparam int LVLS = (LW > 1) ? $clog2(LW) : 1;

  generate
    if (CHAIN == CHAIN_RIPPLE) begin : g_ripple
      logic [WIDTH:0] acc;
      always_comb begin
        acc[0] = seed_i;
        for (int k = 0; k < WIDTH; k++) begin
          acc[k+1] = acc[k] ^ bits_i[k];
        end
      end
      assign lines_o = acc;
    end else begin : g_prefix
      // log-depth parallel prefix over {bits, seed}
      logic [LVLS:0][WIDTH:0] st;
      assign st[0] = {bits_i, seed_i};
      for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        for (genvar i = 0; i < LW; i++) begin : g_el
          if (i >= (1 << l)) begin : g_comb
            assign st[l+1][i] = st[l][i] ^ st[l][i-(1<<l)];
          end else begin : g_pass
            assign st[l+1][i] = st[l][i];
          end
        end
      end
      assign lines_o = st[LVLS];
    end
  endgenerate

  // R3
  always_comb begin
    last_line_parity_chk: assert (lines_o[WIDTH] == (seed_i ^ (^bits_i)));
  end
endmodule

// File: rtl/incr_bus_enc.sv
module incr_bus_enc
  import incr_bus_pkg::*;
#(
  parameter int     WIDTH   = 6,
  parameter logic   SEED    = 1'b0,
  parameter chain_e CHAIN   = CHAIN_PREFIX,
  parameter int     ENC_LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             valid_i,
  output logic [WIDTH:0]   line_o,
  output logic             valid_o
);
  localparam int LW = WIDTH + 1;

  logic [WIDTH:0] scan;

  incr_xor_scan #(
    .WIDTH (WIDTH),
    .CHAIN (CHAIN)
  ) u_scan (
    .seed_i  (SEED),
    .bits_i  (data_i),
    .lines_o (scan)
  );

  // register stages behind the scan, free to be retimed into it
  logic [ENC_LAT-1:0][LW-1:0] pipe_q;
  logic [ENC_LAT-1:0]         vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      vld_q  <= '0;
    end else begin
      vld_q[0] <= valid_i;
      if (valid_i) pipe_q[0] <= scan;
      for (int s = 1; s < ENC_LAT; s++) begin
        vld_q[s] <= vld_q[s-1];
        if (vld_q[s-1]) pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign line_o  = pipe_q[ENC_LAT-1];
  assign valid_o = vld_q[ENC_LAT-1];

  // R2
  line0_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> line_o[0] == SEED);

  // R7
  enc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(line_o));
endmodule

// File: rtl/incr_bus_dec.sv
module incr_bus_dec #(
  parameter int WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH:0]   line_i,
  input  logic             valid_i,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o
);
  logic [WIDTH-1:0] data_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) data_q <= line_i[WIDTH:1] ^ line_i[WIDTH-1:0];
    end
  end

  assign data_o  = data_q;
  assign valid_o = vld_q;

  // R5
  dec_valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R5
  dec_valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R6: word parity depends only on the two end lines
  dec_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (^data_o) == ($past(line_i[WIDTH]) ^ $past(line_i[0])));

  // R7
  dec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
endmodule

// File: rtl/incr_bus_codec.sv
module incr_bus_codec
  import incr_bus_pkg::*;
#(
  parameter int     WIDTH   = 6,
  parameter logic   SEED    = 1'b0,
  parameter chain_e CHAIN   = CHAIN_PREFIX,
  parameter int     ENC_LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] tx_data_i,
  input  logic             tx_valid_i,
  output logic [WIDTH:0]   line_o,
  output logic             line_valid_o,
  input  logic [WIDTH:0]   rx_line_i,
  input  logic             rx_valid_i,
  output logic [WIDTH-1:0] rx_data_o,
  output logic             rx_valid_o
);
  incr_bus_enc #(
    .WIDTH   (WIDTH),
    .SEED    (SEED),
    .CHAIN   (CHAIN),
    .ENC_LAT (ENC_LAT)
  ) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (tx_data_i),
    .valid_i (tx_valid_i),
    .line_o  (line_o),
    .valid_o (line_valid_o)
  );

  incr_bus_dec #(
    .WIDTH (WIDTH)
  ) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (rx_line_i),
    .valid_i (rx_valid_i),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o)
  );
endmodule

// File: tb/incr_bus_codec_tb_top.sv
module incr_bus_codec_tb_top;
  import incr_bus_pkg::*;

  localparam int   CLK_PERIOD = 10;
  localparam int   W      = 6;
  localparam int   LW     = W + 1;
  localparam logic SEED_A = 1'b0;
  localparam int   LAT_A  = 2;
  localparam logic SEED_B = 1'b1;
  localparam int   LAT_B  = 3;
  localparam int   NCYC   = 1500;
  localparam int   NEXP   = NCYC + 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0]  tx_data;
  logic          tx_valid;
  logic          inv;
  logic [LW-1:0] line_a, line_b, rxl_a, rxl_b;
  logic          lv_a, lv_b;
  logic [W-1:0]  rd_a, rd_b;
  logic          rv_a, rv_b;

  assign rxl_a = line_a ^ {LW{inv}};
  assign rxl_b = line_b ^ {LW{inv}};

  incr_bus_codec #(.WIDTH(W), .SEED(SEED_A), .CHAIN(CHAIN_PREFIX), .ENC_LAT(LAT_A)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .line_o(line_a), .line_valid_o(lv_a), .rx_line_i(rxl_a), .rx_valid_i(lv_a),
    .rx_data_o(rd_a), .rx_valid_o(rv_a));

  incr_bus_codec #(.WIDTH(W), .SEED(SEED_B), .CHAIN(CHAIN_RIPPLE), .ENC_LAT(LAT_B)) dut_rip_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .line_o(line_b), .line_valid_o(lv_b), .rx_line_i(rxl_b), .rx_valid_i(lv_b),
    .rx_data_o(rd_b), .rx_valid_o(rv_b));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic          ea_v [NEXP];
  logic [LW-1:0] ea_l [NEXP];
  logic          ra_v [NEXP];
  logic [W-1:0]  ra_d [NEXP];
  logic          eb_v [NEXP];
  logic [LW-1:0] eb_l [NEXP];
  logic          rb_v [NEXP];
  logic [W-1:0]  rb_d [NEXP];
  logic [LW-1:0] last_la, last_lb;
  logic [W-1:0]  last_ra, last_rb;

  function automatic logic [LW-1:0] enc_model(input logic [W-1:0] d, input logic s);
    logic [LW-1:0] l;
    l[0] = s;
    for (int k = 0; k < W; k++) l[k+1] = l[k] ^ d[k];
    return l;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_cycle(input int c);
    // copy A: prefix tree, seed 0
    if (ea_v[c]) begin
      chk(lv_a == 1'b1 && line_a == ea_l[c], "R3/R4 lines A", {8'(lv_a), 8'(line_a)}, {8'h1, 8'(ea_l[c])});
      chk(line_a[0] == SEED_A, "R2 seed line A", 16'(line_a[0]), 16'(SEED_A));
      last_la = ea_l[c];
    end else begin
      chk(lv_a == 1'b0 && line_a == last_la, "R7 hold lines A", {8'(lv_a), 8'(line_a)}, {8'h0, 8'(last_la)});
    end
    if (ra_v[c]) begin
      chk(rv_a == 1'b1 && rd_a == ra_d[c], "R5/R6 decode A", {8'(rv_a), 8'(rd_a)}, {8'h1, 8'(ra_d[c])});
      last_ra = ra_d[c];
    end else begin
      chk(rv_a == 1'b0 && rd_a == last_ra, "R7 hold decode A", {8'(rv_a), 8'(rd_a)}, {8'h0, 8'(last_ra)});
    end
    // copy B: ripple chain, seed 1
    if (eb_v[c]) begin
      chk(lv_b == 1'b1 && line_b == eb_l[c], "R8 lines B", {8'(lv_b), 8'(line_b)}, {8'h1, 8'(eb_l[c])});
      chk(line_b[0] == SEED_B, "R2 seed line B", 16'(line_b[0]), 16'(SEED_B));
      last_lb = eb_l[c];
    end else begin
      chk(lv_b == 1'b0 && line_b == last_lb, "R7 hold lines B", {8'(lv_b), 8'(line_b)}, {8'h0, 8'(last_lb)});
    end
    if (rb_v[c]) begin
      chk(rv_b == 1'b1 && rd_b == rb_d[c], "R8/R6 decode B", {8'(rv_b), 8'(rd_b)}, {8'h1, 8'(rb_d[c])});
      last_rb = rb_d[c];
    end else begin
      chk(rv_b == 1'b0 && rd_b == last_rb, "R7 hold decode B", {8'(rv_b), 8'(rd_b)}, {8'h0, 8'(last_rb)});
    end
  endtask

  initial begin
    logic [W-1:0] word;
    logic         vld;
    void'($urandom(32'd1234));
    for (int i = 0; i < NEXP; i++) begin
      ea_v[i] = 1'b0; ra_v[i] = 1'b0; eb_v[i] = 1'b0; rb_v[i] = 1'b0;
      ea_l[i] = '0;   ra_d[i] = '0;   eb_l[i] = '0;   rb_d[i] = '0;
    end
    last_la = '0; last_lb = '0; last_ra = '0; last_rb = '0;
    tx_data = '1; tx_valid = 1'b1; inv = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(lv_a == 1'b0 && line_a == '0, "R1 reset lines A", {8'(lv_a), 8'(line_a)}, 16'h0);
    chk(rv_a == 1'b0 && rd_a == '0, "R1 reset decode A", {8'(rv_a), 8'(rd_a)}, 16'h0);
    chk(lv_b == 1'b0 && line_b == '0, "R1 reset lines B", {8'(lv_b), 8'(line_b)}, 16'h0);
    chk(rv_b == 1'b0 && rd_b == '0, "R1 reset decode B", {8'(rv_b), 8'(rd_b)}, 16'h0);
    tx_valid = 1'b0;
    rst_n = 1'b1;
    for (int c = 0; c < NCYC + 8; c++) begin
      if (c > 0) @(negedge clk);
      check_cycle(c);
      // directed corners first, then random traffic, then drain
      case (c)
        0: begin word = '0;              vld = 1'b1; end
        1: begin word = '1;              vld = 1'b1; end
        2: begin word = 6'b010101;       vld = 1'b1; end
        3: begin word = 6'b101010;       vld = 1'b1; end
        4: begin word = 6'b000001;       vld = 1'b1; end
        5: begin word = 6'b100000;       vld = 1'b0; end
        6: begin word = 6'b100000;       vld = 1'b1; end
        default: begin
          word = W'($urandom);
          vld  = (c < NCYC) && (($urandom % 4) != 0);
        end
      endcase
      tx_data  = word;
      tx_valid = vld;
      inv      = 1'($urandom);
      if (vld) begin
        ea_v[c+LAT_A]   = 1'b1; ea_l[c+LAT_A]   = enc_model(word, SEED_A);
        ra_v[c+LAT_A+1] = 1'b1; ra_d[c+LAT_A+1] = word;
        eb_v[c+LAT_B]   = 1'b1; eb_l[c+LAT_B]   = enc_model(word, SEED_B);
        rb_v[c+LAT_B+1] = 1'b1; rb_d[c+LAT_B+1] = word;
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule